// File: doc/BRIEF.md
# Power Domain Sequencing Controller

The controller turns a set of power domains off and on at the request of software over a simple memory-mapped bus. Software first checks a common ready flag. It then writes a one to a domain's request bit in either the shutoff or the resume register. Right after the write it reads that channel's error bit, and if the bit is set it submits the request again. The controller runs one transition at a time. While a transition runs, it holds its ready flags low. The power switch itself is modelled as a fixed number of clock cycles. Each power switch is driven from a per-domain output.

When a transition completes, the controller sets the domain's bit in a shared interrupt status register, provided that source is enabled. A write-one-to-clear register clears that bit. A separate mask register keeps an enabled source from reaching the interrupt pin. This lets software poll for completion without taking interrupts. A request that would leave a domain in the state it already has completes at once, and no transition takes place.

The common registers sit at 0x00 to 0x10. Domain i has a 32-byte channel block at 0x40 + 0x20*i. Inside each channel the domain uses bit 0 of every register.

Top module: `pwr_area_ctrl`

## Requirements
- R1: After reset, every domain is off, which means `dom_on` is all zero and channel power status bit 0 reads 1. The interrupt status, enable and mask registers read 0, the common status reads 3, and `irq` is low.
- R2: Common status (0x00) reads 3 when the controller is idle. Bit 1 means ready for resume and bit 0 means ready for shutoff. It reads 0 on every cycle in which a transition is in progress.
- R3: An idle controller accepts a write with data bit 0 set to a channel's shutoff register (+0x04) or resume register (+0x0C), provided the request would change the domain's state. The transition then lasts SWITCH_CYCLES cycles. During it, channel shutoff status (+0x08) or resume status (+0x10) bit 0 reads 1. At its end the domain's power state flips. A control write with data bit 0 clear has no effect.
- R4: A request written while a transition is in progress is not performed and sets the channel's error bit (+0x14, bit 0). The next accepted request to that channel clears the bit.
- R5: A request that would leave a domain in the state it already has completes in the cycle after the write. It produces no busy period and leaves the power state unchanged.
- R6: On completion, interrupt status (0x04) bit i is set only if enable (0x0C) bit i is set.
- R7: Writing ones to 0x08 clears the matching interrupt status bits, and 0x08 reads 0. If a completion and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when some bit is set in interrupt status and in enable and is clear in mask (0x10). A masked completion still sets its status bit.
- R9: Reads of an unmapped address, of a control register, or of a channel beyond NUM_DOM return 0.
- R10: A power state changes only at the end of a transition. Each transition is complete within SWITCH_CYCLES cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| dom_on | output | NUM_DOM | Power switch enable per domain |

## Verification
Two situations are hard to reach. The first is a request that arrives while another domain's transition is running. The second is a status clear that lands in the very cycle a completion sets the same bit. The stimulus counts cycles from the accepting write, so it can place a second request in mid-transition and put the clear write exactly SWITCH_CYCLES edges after acceptance. A behavioural model in the bench follows every edge. It compares the power outputs and `irq` on every cycle, and it compares every register read.

// File: rtl/pwr_area_ctrl.sv
module pwr_area_ctrl #(
  parameter int NUM_DOM       = 4,
  parameter int SWITCH_CYCLES = 20,
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic [NUM_DOM-1:0] dom_on
);
  localparam int CNT_W = $clog2(SWITCH_CYCLES + 1);
  localparam int IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int BLK_W = ADDR_W - 5;

  logic [NUM_DOM-1:0] pwr_off, err, isr, ier, imr;
  logic               busy, dir_off;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   act;

  wire              wr     = bus_sel & bus_wr;
  wire [BLK_W-1:0]  blk    = bus_addr[ADDR_W-1:5];
  wire [4:0]        reg_off = bus_addr[4:0];
  wire [BLK_W-1:0]  ch_num = blk - BLK_W'(2);
  wire              ch_hit = (blk >= BLK_W'(2)) && (ch_num < BLK_W'(NUM_DOM));
  wire [IDX_W-1:0]  ch_idx = ch_num[IDX_W-1:0];
  wire              common = (blk == '0);

  wire req_off = wr & ch_hit & (reg_off == 5'h04) & bus_wdata[0];
  wire req_on  = wr & ch_hit & (reg_off == 5'h0C) & bus_wdata[0];
  wire req     = req_off | req_on;
  wire accept  = req & ~busy;
  wire same    = (pwr_off[ch_idx] == req_off);
  wire start   = accept & ~same;
  wire instant = accept & same;
  wire done    = busy & (cnt == '0);

  wire [NUM_DOM-1:0] act_bit = NUM_DOM'(1) << act;
  wire [NUM_DOM-1:0] ch_bit  = NUM_DOM'(1) << ch_idx;
  wire [NUM_DOM-1:0] set_b   = ((done ? act_bit : '0) | (instant ? ch_bit : '0)) & ier;
  wire [NUM_DOM-1:0] clr_b   = (wr & common & reg_off == 5'h08) ? bus_wdata[NUM_DOM-1:0] : '0;
  wire unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_off <= '1;
      err     <= '0;
      isr     <= '0;
      ier     <= '0;
      imr     <= '0;
      busy    <= 1'b0;
      dir_off <= 1'b0;
      cnt     <= '0;
      act     <= '0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(SWITCH_CYCLES - 1);
        act     <= ch_idx;
        dir_off <= req_off;
      end else if (done) begin
        busy         <= 1'b0;
        pwr_off[act] <= dir_off;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (req) err[ch_idx] <= busy;
      isr <= (isr & ~clr_b) | set_b;
      if (wr && common && reg_off == 5'h0C) ier <= bus_wdata[NUM_DOM-1:0];
      if (wr && common && reg_off == 5'h10) imr <= bus_wdata[NUM_DOM-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (common) begin
        case (reg_off)
          5'h00:   bus_rdata = {{(DATA_W-2){1'b0}}, ~busy, ~busy};
          5'h04:   bus_rdata = DATA_W'(isr);
          5'h0C:   bus_rdata = DATA_W'(ier);
          5'h10:   bus_rdata = DATA_W'(imr);
          default: bus_rdata = '0;
        endcase
      end else if (ch_hit) begin
        case (reg_off)
          5'h00:   bus_rdata = DATA_W'(pwr_off[ch_idx]);
          5'h08:   bus_rdata = DATA_W'(busy && act == ch_idx && dir_off);
          5'h10:   bus_rdata = DATA_W'(busy && act == ch_idx && !dir_off);
          5'h14:   bus_rdata = DATA_W'(err[ch_idx]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq    = |(isr & ier & ~imr);
  assign dom_on = ~pwr_off;
endmodule

// File: rtl/pwr_area_ctrl_chk.sv
module pwr_area_ctrl_chk #(
  parameter int NUM_DOM       = 4,
  parameter int SWITCH_CYCLES = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               irq,
  input logic [NUM_DOM-1:0] isr,
  input logic [NUM_DOM-1:0] dom_on
);
  logic [31:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 1 : '0;
  end

  assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 32'(SWITCH_CYCLES));
  assert_change_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_on != $past(dom_on)) |-> $past(busy));
  assert_one_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dom_on ^ $past(dom_on)) <= 1);
  assert_end_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (dom_on != $past(dom_on)));
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr != '0));
endmodule

bind pwr_area_ctrl pwr_area_ctrl_chk #(.NUM_DOM(NUM_DOM), .SWITCH_CYCLES(SWITCH_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .isr(isr), .dom_on(dom_on));

// File: tb/pwr_area_ctrl_tb_top.sv
module pwr_area_ctrl_tb_top;
  localparam int N = 4;
  localparam int S = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [N-1:0] dom_on;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_area_ctrl #(.NUM_DOM(N), .SWITCH_CYCLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .dom_on(dom_on));

  // behavioural reference model
  int m_off[N];
  int m_err[N];
  bit m_busy, m_dir;
  int m_cnt, m_act;
  bit [31:0] m_isr, m_ier, m_imr;
  int ch, old_busy, fin, rq, roff;
  bit [31:0] setb, clrb;
  localparam bit [31:0] MASK = (32'd1 << N) - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_off[i] = 1; m_err[i] = 0; end
      m_busy = 0; m_cnt = 0; m_act = 0; m_dir = 0;
      m_isr = 0; m_ier = 0; m_imr = 0;
    end else begin
      old_busy = m_busy;
      fin = (m_busy && m_cnt == 0);
      setb = 0; clrb = 0; rq = 0; roff = 0; ch = -1;
      if (sel && wr && addr >= 64) begin
        ch = (int'(addr) - 64) / 32;
        if (ch < N && (addr % 32 == 4 || addr % 32 == 12) && wdata[0]) begin
          rq = 1; roff = (addr % 32 == 4);
        end
      end
      if (fin) begin
        setb[m_act] = 1; m_off[m_act] = m_dir; m_busy = 0;
      end else if (m_busy) m_cnt--;
      if (rq) begin
        m_err[ch] = old_busy;
        if (!old_busy) begin
          if (m_off[ch] == roff) setb[ch] = 1;
          else begin m_busy = 1; m_cnt = S - 1; m_act = ch; m_dir = roff[0]; end
        end
      end
      if (sel && wr && addr == 12'h008) clrb = wdata & MASK;
      m_isr = (m_isr & ~clrb) | (setb & m_ier);
      if (sel && wr && addr == 12'h00C) m_ier = wdata & MASK;
      if (sel && wr && addr == 12'h010) m_imr = wdata & MASK;
    end
  end

  function automatic bit [31:0] m_read(input bit [11:0] a);
    int c;
    if (a == 12'h000) return m_busy ? 0 : 3;
    if (a == 12'h004) return m_isr;
    if (a == 12'h00C) return m_ier;
    if (a == 12'h010) return m_imr;
    if (a < 64) return 0;
    c = (int'(a) - 64) / 32;
    if (c >= N) return 0;
    case (a % 32)
      0:  return 32'(m_off[c]);
      8:  return 32'(m_busy && m_act == c && m_dir);
      16: return 32'(m_busy && m_act == c && !m_dir);
      20: return 32'(m_err[c]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit w, input bit [11:0] a, input bit [31:0] d, input string tag);
    bit [N-1:0] eon;
    @(negedge clk);
    for (int i = 0; i < N; i++) eon[i] = (m_off[i] == 0);
    chk("R3 dom_on", 32'(dom_on), 32'(eon));
    chk("R8 irq", 32'(irq), 32'(|(m_isr & m_ier & ~m_imr)));
    sel = s; wr = w; addr = a; wdata = d;
    #1;
    if (s && !w) chk(tag, rdata, m_read(a));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "");
  endtask
  task automatic rd(input bit [11:0] a, input string tag); step(1, 0, a, 0, tag); endtask
  task automatic wrr(input bit [11:0] a, input bit [31:0] d); step(1, 1, a, d, ""); endtask
  function automatic bit [11:0] cha(input int c, input int o); return 12'(64 + 32 * c + o); endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(12'h000, "R1 status"); rd(12'h004, "R1 isr"); rd(12'h00C, "R1 ier"); rd(12'h010, "R1 imr");
    for (int c = 0; c < N; c++) rd(cha(c, 0), "R1 power status");
    // R6 enable domains 0..2 only
    wrr(12'h00C, 32'h7); rd(12'h00C, "R6 ier");
    // R3 resume domain 0
    wrr(cha(0, 12), 1);
    rd(12'h000, "R2 busy status"); rd(cha(0, 16), "R3 resume status");
    // R4 request to domain 1 while busy
    wrr(cha(1, 12), 1); rd(cha(1, 20), "R4 error set");
    idle(S);
    rd(12'h000, "R2 idle status"); rd(12'h004, "R6 isr"); rd(cha(0, 0), "R3 power status");
    // R4 retry clears error
    wrr(cha(1, 12), 1); rd(cha(1, 20), "R4 error cleared");
    idle(S + 1);
    // R7 clear
    wrr(12'h008, 32'h3); rd(12'h004, "R7 isr cleared"); rd(12'h008, "R7 clear reads zero");
    // R5 redundant request
    wrr(cha(0, 12), 1); rd(12'h000, "R5 no busy"); rd(12'h004, "R5 isr"); rd(cha(0, 0), "R5 state kept");
    wrr(12'h008, 32'h1);
    // R3 write with bit0 clear ignored
    wrr(cha(2, 12), 32'h2); rd(12'h000, "R3 ignored status"); rd(cha(2, 0), "R3 ignored power");
    // R8 masked completion
    wrr(12'h010, 32'h4); wrr(cha(2, 12), 1); idle(S + 1);
    rd(12'h004, "R8 masked isr set");
    wrr(12'h010, 32'h0); idle(1); wrr(12'h008, 32'h4);
    // R6 disabled source
    wrr(cha(3, 12), 1); idle(S + 1); rd(12'h004, "R6 disabled isr");
    // R7 clear in completion cycle
    wrr(cha(0, 4), 1); idle(S - 1); wrr(12'h008, 32'h1);
    rd(12'h004, "R7 set wins"); rd(cha(0, 0), "R10 shutoff done");
    // R9 unmapped
    rd(12'h020, "R9 unmapped"); rd(cha(N, 0), "R9 beyond channels"); rd(cha(1, 4), "R9 control read");
    // R10 final power state
    for (int c = 0; c < N; c++) rd(cha(c, 0), "R10 final power status");
    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule